// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block derives an average 1 MHz tick enable from whatever reference clock it runs on. A 16-bit ratio word holds two byte fields, each stored as its value minus one: the low byte is the number of reference cycles in one averaging period (N), and the high byte is the number of ticks issued in that period (D). A remainder accumulator spreads the D ticks across the N cycles as evenly as it can. Reference rates that are not whole multiples of 1 MHz, such as 19.2 MHz or 38.4 MHz, therefore still give an exact long-term rate. Downstream timer channels use `tick_o` as their count enable.

The block also keeps a 32-bit microsecond counter that steps on every tick and wraps freely. A freeze bit in a register, or a freeze input pin, holds the counter while ticks keep flowing. A plain write strobe and a combinational read port give access to the counter, the ratio word and the freeze bit.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset the ratio word reads 0x000B, the counter reads 0, the freeze bit reads 0 and `tick_o` is low.
- R2: For a ratio word with low byte L and high byte H (H not above L), exactly H+1 ticks appear in the first L+1 cycles after the ratio word is written. The internal remainder always stays below L+1.
- R3: With H equal to 0, `tick_o` is high in cycle L+1 after the ratio write and in no earlier cycle. Cycle k is the state after the k-th rising edge following the write edge.
- R4: A ratio write clears the accumulator and forces `tick_o` low on its edge, so a rewrite in the middle of a period restarts the period.
- R5: When H is greater than L, `tick_o` is high in every cycle after the ratio write.
- R6: In each cycle where `tick_o` is high and the counter is not frozen, the counter has grown by exactly one, modulo 2^32. The counter does not move on the edge of a ratio write.
- R7: While the freeze bit (bit 0 at offset 0xC) or `freeze_in` is 1, the counter holds its value and `tick_o` keeps pulsing at the programmed rate.
- R8: Reads at offset 0x0 return the counter, at 0x4 return the ratio word in bits 15:0, at 0xC return the freeze bit in bit 0, and at any other offset return 0.
- R9: Writes to offset 0x0 or to an unmapped offset have no effect on the counter or the ratio word.
- R10: Ratio word 0x045F gives ticks in cycles 20, 39, 58, 77 and 96 after the write, which is 5 ticks per 96 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 4 | Write offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 32 | Read data, combinational on `rd_addr` |
| freeze_in | input | 1 | Holds the counter while high |
| tick_o | output | 1 | Tick enable |

## Verification
A ratio write takes effect on the edge that samples the strobe. The tick and the counter step of period cycle k are both visible after the k-th following edge, because the counter advances on the same edge that registers `tick_o`. The bench therefore numbers cycles from the write edge and samples on the falling edge after each rising edge. Reads are combinational, so the bench sets the offset on a falling edge and samples a moment later, before the next rising edge, and it takes counter snapshots right after the write edge and right after the last cycle of a window.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;

  localparam int UT_FIELD_W = 8;
  localparam int UT_CFG_W   = 2 * UT_FIELD_W;
  localparam int UT_ACC_W   = UT_FIELD_W + 1;

  typedef logic [UT_ACC_W-1:0] acc_t;

  // high byte: ticks per period minus one; low byte: cycles per period minus one
  typedef struct packed {
    logic [UT_FIELD_W-1:0] den_m1;
    logic [UT_FIELD_W-1:0] num_m1;
  } ratio_cfg_t;

  typedef struct packed {
    acc_t acc;
    logic hit;
  } step_t;

  function automatic acc_t cfg_num(input ratio_cfg_t c);
    return acc_t'({1'b0, c.num_m1}) + acc_t'(1);
  endfunction

  function automatic acc_t cfg_den(input ratio_cfg_t c);
    return acc_t'({1'b0, c.den_m1}) + acc_t'(1);
  endfunction

  // One reference cycle of the remainder accumulator. The remainder is
  // clamped below the period length so that ratios under one saturate.
  function automatic step_t acc_step(input acc_t acc, input ratio_cfg_t c);
    step_t r;
    acc_t  num;
    acc_t  sum;
    acc_t  rem;
    num = cfg_num(c);
    sum = acc + cfg_den(c);
    rem = sum - num;
    if (sum >= num) begin
      r.hit = 1'b1;
      r.acc = (rem >= num) ? (num - acc_t'(1)) : rem;
    end else begin
      r.hit = 1'b0;
      r.acc = sum;
    end
    return r;
  endfunction

endpackage

// File: rtl/ut_ratio_regs.sv
module ut_ratio_regs
  import usec_tick_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         DATA_W    = 32,
  parameter logic [3:0] OFS_RATIO = 4'h4,
  parameter logic [3:0] OFS_HOLD  = 4'hC,
  parameter logic [15:0] RATIO_RST = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              freeze_in,
  output ratio_cfg_t        cfg,
  output logic              cfg_wr,
  output logic              hold_bit,
  output logic              frozen
);

  logic hold_wr;
  logic unused_wdata;

  assign cfg_wr  = wr_en && (wr_addr == ADDR_W'(OFS_RATIO));
  assign hold_wr = wr_en && (wr_addr == ADDR_W'(OFS_HOLD));
  assign unused_wdata = ^wr_data[DATA_W-1:UT_CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= ratio_cfg_t'(RATIO_RST);
    end else if (cfg_wr) begin
      cfg <= ratio_cfg_t'(wr_data[UT_CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_bit <= 1'b0;
    end else if (hold_wr) begin
      hold_bit <= wr_data[0];
    end
  end

  assign frozen = hold_bit | freeze_in;

endmodule

// File: rtl/ut_frac_accum.sv
module ut_frac_accum
  import usec_tick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ratio_cfg_t cfg,
  input  logic       cfg_wr,
  output acc_t       acc,
  output logic       hit,
  output logic       tick_q
);

  step_t nxt;

  always_comb begin
    nxt = acc_step(acc, cfg);
    hit = nxt.hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      tick_q <= 1'b0;
    end else if (cfg_wr) begin
      acc    <= '0;
      tick_q <= 1'b0;
    end else begin
      acc    <= nxt.acc;
      tick_q <= nxt.hit;
    end
  end

endmodule

// File: rtl/ut_usec_counter.sv
module ut_usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
  import usec_tick_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 32,
  parameter logic [3:0]  OFS_COUNT = 4'h0,
  parameter logic [3:0]  OFS_RATIO = 4'h4,
  parameter logic [3:0]  OFS_HOLD  = 4'hC,
  parameter logic [15:0] RATIO_RST = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              freeze_in,
  output logic              tick_o
);

  localparam int CFG_PAD = DATA_W - UT_CFG_W;
  localparam int CNT_PAD = DATA_W - CNT_W;

  ratio_cfg_t       cfg;
  logic             cfg_wr;
  logic             hold_bit;
  logic             frozen;
  acc_t             acc;
  logic             hit;
  logic             cnt_step;
  logic [CNT_W-1:0] count;

  ut_ratio_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OFS_RATIO(OFS_RATIO),
    .OFS_HOLD (OFS_HOLD),
    .RATIO_RST(RATIO_RST)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .freeze_in(freeze_in),
    .cfg      (cfg),
    .cfg_wr   (cfg_wr),
    .hold_bit (hold_bit),
    .frozen   (frozen)
  );

  ut_frac_accum accum_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   (cfg),
    .cfg_wr(cfg_wr),
    .acc   (acc),
    .hit   (hit),
    .tick_q(tick_o)
  );

  // the counter steps on the same edge that registers the tick
  assign cnt_step = hit && !frozen && !cfg_wr;

  ut_usec_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .step (cnt_step),
    .count(count)
  );

  logic [DATA_W-1:0] cnt_word;
  generate
    if (CNT_PAD > 0) begin : g_cnt_pad
      assign cnt_word = {{CNT_PAD{1'b0}}, count};
    end else begin : g_cnt_full
      assign cnt_word = count;
    end
  endgenerate

  always_comb begin
    if (rd_addr == ADDR_W'(OFS_COUNT)) begin
      rd_data = cnt_word;
    end else if (rd_addr == ADDR_W'(OFS_RATIO)) begin
      rd_data = {{CFG_PAD{1'b0}}, cfg};
    end else if (rd_addr == ADDR_W'(OFS_HOLD)) begin
      rd_data = {{(DATA_W-1){1'b0}}, hold_bit};
    end else begin
      rd_data = '0;
    end
  end

endmodule

// File: rtl/usec_tick_gen_chk.sv
module usec_tick_gen_chk
  import usec_tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input ratio_cfg_t       cfg,
  input logic             cfg_wr,
  input logic             frozen,
  input acc_t             acc,
  input logic             hit,
  input logic             tick_o,
  input logic [CNT_W-1:0] count
);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !frozen && !cfg_wr) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (count == $past(count)));

  // R7
  tick_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && hit && !cfg_wr) |=> tick_o);

  // R4
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!tick_o && acc == '0));

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc < cfg_num(cfg));

  // R5
  fast_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.den_m1 > cfg.num_m1 && !cfg_wr) |=> tick_o);

endmodule

bind usec_tick_gen usec_tick_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .cfg   (cfg),
  .cfg_wr(cfg_wr),
  .frozen(frozen),
  .acc   (acc),
  .hit   (hit),
  .tick_o(tick_o),
  .count (count)
);

// File: tb/usec_tick_gen_tb_top.sv
module usec_tick_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        freeze_in = 1'b0;
  logic        tick_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usec_tick_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .freeze_in(freeze_in),
    .tick_o   (tick_o)
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic [15:0] cycles;
    logic [15:0] ticks;
    logic [15:0] first;
  } vec_t;

  // ticks and first tick computed from (H+1)/(L+1): first = ceil((L+1)/(H+1))
  localparam vec_t VEC [8] = '{
    '{16'h000B, 16'd12,  16'd1, 16'd12},
    '{16'h045F, 16'd96,  16'd5, 16'd20},
    '{16'h04BF, 16'd192, 16'd5, 16'd39},
    '{16'h002F, 16'd48,  16'd1, 16'd48},
    '{16'h0019, 16'd26,  16'd1, 16'd26},
    '{16'h043F, 16'd64,  16'd5, 16'd13},
    '{16'h0000, 16'd8,   16'd8, 16'd1},
    '{16'h0302, 16'd8,   16'd8, 16'd1}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // counts ticks over n cycles after the current falling edge
  task automatic run(input int n, output int ticks, output int first);
    ticks = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (tick_o) begin
        ticks++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0, c1;
    int tk, fst;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(tick_o == 1'b0, "R1 tick after reset", tick_o, 0);
    reg_rd(4'h4, d); check(d == 32'h000B, "R1 ratio reset", d, 32'h000B);
    reg_rd(4'h0, d); check(d == 32'h0, "R1 counter reset", d, 0);
    reg_rd(4'hC, d); check(d == 32'h0, "R1 freeze reset", d, 0);

    // table walk: R2 count, R3/R5 first tick, R6 counter delta
    for (int v = 0; v < 8; v++) begin
      reg_wr(4'h4, {16'h0, VEC[v].cfg});
      reg_rd(4'h0, c0);
      run(int'(VEC[v].cycles), tk, fst);
      reg_rd(4'h0, c1);
      check(tk == int'(VEC[v].ticks), $sformatf("R2 ticks cfg=%h", VEC[v].cfg), tk, VEC[v].ticks);
      check(fst == int'(VEC[v].first), $sformatf("R3 R5 first tick cfg=%h", VEC[v].cfg), fst, VEC[v].first);
      check(c1 - c0 == 32'(VEC[v].ticks), $sformatf("R6 counter delta cfg=%h", VEC[v].cfg), c1 - c0, VEC[v].ticks);
    end

    // R5 ratio below one: every cycle over a longer run
    reg_wr(4'h4, 32'h0000_0500);
    run(20, tk, fst);
    check(tk == 20, "R5 tick every cycle", tk, 20);

    // R10 exact tick positions for 0x045F
    reg_wr(4'h4, 32'h0000_045F);
    begin
      int pos [5];
      int k;
      k = 0;
      for (int i = 1; i <= 96; i++) begin
        @(posedge clk);
        @(negedge clk);
        if (tick_o && k < 5) begin pos[k] = i; k++; end
      end
      check(k == 5, "R10 tick count", k, 5);
      check(pos[0] == 20 && pos[1] == 39 && pos[2] == 58 && pos[3] == 77 && pos[4] == 96,
            "R10 tick positions", (pos[0] << 8) | pos[4], (20 << 8) | 96);
    end

    // R4 mid-period rewrite restarts the period
    reg_wr(4'h4, 32'h0000_000B);
    run(6, tk, fst);
    reg_wr(4'h4, 32'h0000_000B);
    run(12, tk, fst);
    check(fst == 12 && tk == 1, "R4 restart after rewrite", fst, 12);
    reg_rd(4'h4, d); check(d == 32'h000B, "R8 ratio readback", d, 32'h000B);

    // R7 freeze via register
    reg_wr(4'hC, 32'h1);
    reg_rd(4'hC, d); check(d == 32'h1, "R8 freeze readback", d, 1);
    reg_wr(4'h4, 32'h0000_000B);
    reg_rd(4'h0, c0);
    run(48, tk, fst);
    reg_rd(4'h0, c1);
    check(tk == 4, "R7 ticks while frozen by register", tk, 4);
    check(c1 == c0, "R7 counter held by register", c1, c0);

    // R9 ignored writes, counter held so it must stay exactly
    reg_wr(4'h0, 32'h1234_5678);
    reg_rd(4'h0, d); check(d == c0, "R9 counter write ignored", d, c0);
    reg_wr(4'h8, 32'h0000_0055);
    reg_rd(4'h4, d); check(d == 32'h000B, "R9 unmapped write ratio", d, 32'h000B);
    reg_rd(4'h0, d); check(d == c0, "R9 unmapped write counter", d, c0);
    reg_rd(4'h8, d); check(d == 32'h0, "R8 unmapped read zero", d, 0);

    // R7 freeze via pin
    reg_wr(4'hC, 32'h0);
    freeze_in = 1'b1;
    reg_wr(4'h4, 32'h0000_000B);
    reg_rd(4'h0, c0);
    run(24, tk, fst);
    reg_rd(4'h0, c1);
    check(tk == 2, "R7 ticks while frozen by pin", tk, 2);
    check(c1 == c0, "R7 counter held by pin", c1, c0);

    // release and resume
    freeze_in = 1'b0;
    reg_wr(4'h4, 32'h0000_000B);
    reg_rd(4'h0, c0);
    run(12, tk, fst);
    reg_rd(4'h0, c1);
    check(c1 - c0 == 32'd1, "R6 R7 counter resumes", c1 - c0, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule